// File: doc/BRIEF.md
# Remap Tag Buffer

This block sits inside a memory controller that uses in-package DRAM as a page-granular, 4-way set-associative cache. When a page is moved into or out of that cache, the translation entries held by the cores still describe the old placement. The buffer records the newest placement for those recently moved pages. Every memory request presents its physical page number together with the placement carried by its translation entry. The buffer answers one cycle later with the placement to use: its own copy if it holds the page, otherwise the supplied value unchanged.

Remap events write entries. A remap of a page that is already held rewrites that entry. A remap of a new page takes the lowest free slot. Coherence is lazy: nothing is requested from software until the last free slot is taken. At that point the buffer raises a flush request and waits. Software then updates the page tables, shoots down the translation buffers and returns an acknowledge. In the acknowledge cycle every entry is invalidated at once. While the request is pending, lookups are still answered and remaps of pages already held are still accepted. Remaps of new pages are held off with `ins_ready` low.

Control is a two-state machine. In ACCEPT, inserts are always taken. The FILL transition (ACCEPT to FLUSH_WAIT) fires on the edge where an insert takes the last free slot. In FLUSH_WAIT, `flush_req` is high. The ACK transition (FLUSH_WAIT to ACCEPT) fires on an edge where `flush_ack` is high, and it clears all entries.

Top module: `remap_tag_buffer`

## Requirements
- R1: After reset, `flush_req` and `lk_out_valid` are low, `ins_ready` is high and the buffer holds no entry.
- R2: A lookup presented with `lk_valid` high at a clock edge gives `lk_out_valid` high after that edge. When `lk_valid` is low, `lk_out_valid` is low after the edge.
- R3: A lookup hit gives `lk_out_hit` = 1 and the stored mapping. Bit MAP_W-1 of a mapping is the cached flag and the bits below it are the way index. A hit reflects the contents before any insert or clear on the same edge.
- R4: A lookup miss gives `lk_out_hit` = 0 and `lk_out_map` equal to the `lk_map_in` sampled with the request.
- R5: An accepted insert whose page is already held replaces that entry's mapping and uses no new slot, so the buffer never holds one page twice.
- R6: An accepted insert of a page not held takes a free slot. On the edge where it takes the last free slot, `flush_req` rises.
- R7: While `flush_req` is high, it stays high until acknowledged. `ins_ready` is low for pages not held, and high for pages held when `flush_ack` is low. Lookups continue to be answered.
- R8: `flush_ack` high while `flush_req` is high invalidates every entry on that edge and drops `flush_req`. `ins_ready` is low in that cycle.
- R9: `flush_ack` while `flush_req` is low has no effect. Entries stay and later lookups still hit.
- R10: While `flush_req` is low, `ins_ready` is high. An insert takes effect only on an edge where `ins_valid` and `ins_ready` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_ppn | input | PPN_W | Physical page number to look up |
| lk_map_in | input | MAP_W | Mapping supplied by the translation entry |
| lk_out_valid | output | 1 | Lookup response valid, one cycle after the request |
| lk_out_hit | output | 1 | Page was held by the buffer |
| lk_out_map | output | MAP_W | Mapping to use (cached flag on top, way index below) |
| ins_valid | input | 1 | Remap event |
| ins_ppn | input | PPN_W | Page that was remapped |
| ins_map | input | MAP_W | New mapping for that page |
| ins_ready | output | 1 | Remap event accepted this cycle |
| flush_req | output | 1 | Buffer full, translation coherence requested |
| flush_ack | input | 1 | Software has finished coherence |

## Verification
The assertions assume that `flush_ack` is sampled only at clock edges. They also assume that a stalled insert is simply retried by the source; nothing in them depends on the insert being held stable. The bench drives every input on the falling edge and raises `flush_ack` both while a flush is pending and while none is. A page range slightly larger than the depth makes hits, misses, updates of held pages and repeated fills all occur. A cycle-accurate queue model predicts every response, the ready level and the flush level.

// File: rtl/rtb_pkg.sv
`timescale 1ns/1ps
package rtb_pkg;
    typedef enum logic [0:0] {
        RTB_ACCEPT     = 1'b0,
        RTB_FLUSH_WAIT = 1'b1
    } rtb_state_e;
endpackage

// File: rtl/rtb_cam.sv
`timescale 1ns/1ps
// Parallel tag compare across every slot.
module rtb_cam #(
    parameter int DEPTH = 16,
    parameter int PPN_W = 20
) (
    input  logic [DEPTH-1:0] valid_vec,
    input  logic [PPN_W-1:0] tags [DEPTH],
    input  logic [PPN_W-1:0] key,
    output logic [DEPTH-1:0] match
);
    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign match[g] = valid_vec[g] && (tags[g] == key);
    end
endmodule

// File: rtl/rtb_alloc.sv
`timescale 1ns/1ps
// Lowest-free-slot picker and fill detection.
module rtb_alloc #(
    parameter int DEPTH = 16
) (
    input  logic [DEPTH-1:0] valid_vec,
    output logic [DEPTH-1:0] free_onehot,
    output logic             any_free,
    output logic             last_free
);
    logic [DEPTH-1:0] free_vec;
    logic             taken;

    assign free_vec  = ~valid_vec;
    assign any_free  = |free_vec;
    assign last_free = ($countones(free_vec) == 1);

    always_comb begin
        free_onehot = '0;
        taken       = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (free_vec[i] && !taken) begin
                free_onehot[i] = 1'b1;
                taken          = 1'b1;
            end
        end
    end
endmodule

// File: rtl/rtb_ctrl.sv
`timescale 1ns/1ps
// Fill / lazy-flush control.
module rtb_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic ins_valid,
    input  logic ins_hit,
    input  logic any_free,
    input  logic last_free,
    input  logic flush_ack,
    output logic ins_ready,
    output logic ins_alloc,
    output logic clear_all,
    output logic flush_req
);
    import rtb_pkg::*;

    rtb_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RTB_ACCEPT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d   = state_q;
        ins_ready = 1'b0;
        ins_alloc = 1'b0;
        clear_all = 1'b0;
        flush_req = 1'b0;
        unique case (state_q)
            RTB_ACCEPT: begin
                ins_ready = ins_hit || any_free;
                ins_alloc = ins_valid && !ins_hit && any_free;
                if (ins_alloc && last_free) state_d = RTB_FLUSH_WAIT;
            end
            RTB_FLUSH_WAIT: begin
                flush_req = 1'b1;
                ins_ready = ins_hit && !flush_ack;
                if (flush_ack) begin
                    clear_all = 1'b1;
                    state_d   = RTB_ACCEPT;
                end
            end
            default: state_d = RTB_ACCEPT;
        endcase
    end
endmodule

// File: rtl/remap_tag_buffer.sv
`timescale 1ns/1ps
module remap_tag_buffer #(
    parameter int DEPTH = 16,
    parameter int PPN_W = 20,
    parameter int WAYS  = 4,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1,
    localparam int MAP_W = WAY_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_valid,
    input  logic [PPN_W-1:0] lk_ppn,
    input  logic [MAP_W-1:0] lk_map_in,
    output logic             lk_out_valid,
    output logic             lk_out_hit,
    output logic [MAP_W-1:0] lk_out_map,
    input  logic             ins_valid,
    input  logic [PPN_W-1:0] ins_ppn,
    input  logic [MAP_W-1:0] ins_map,
    output logic             ins_ready,
    output logic             flush_req,
    input  logic             flush_ack
);
    logic [DEPTH-1:0] valid_q;
    logic [PPN_W-1:0] tag_q [DEPTH];
    logic [MAP_W-1:0] map_q [DEPTH];

    logic [DEPTH-1:0] lk_match, ins_match, free_onehot;
    logic             any_free, last_free, ins_hit, ins_alloc, clear_all;
    logic [MAP_W-1:0] lk_map_sel;

    rtb_cam #(.DEPTH(DEPTH), .PPN_W(PPN_W)) u_cam_lk (
        .valid_vec(valid_q), .tags(tag_q), .key(lk_ppn), .match(lk_match));

    rtb_cam #(.DEPTH(DEPTH), .PPN_W(PPN_W)) u_cam_ins (
        .valid_vec(valid_q), .tags(tag_q), .key(ins_ppn), .match(ins_match));

    rtb_alloc #(.DEPTH(DEPTH)) u_alloc (
        .valid_vec(valid_q), .free_onehot(free_onehot),
        .any_free(any_free), .last_free(last_free));

    assign ins_hit = |ins_match;

    rtb_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_hit(ins_hit),
        .any_free(any_free), .last_free(last_free), .flush_ack(flush_ack),
        .ins_ready(ins_ready), .ins_alloc(ins_alloc), .clear_all(clear_all),
        .flush_req(flush_req));

    // Storage: clear beats write; update in place on a hit, else allocate.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                tag_q[i] <= '0;
                map_q[i] <= '0;
            end
        end else if (clear_all) begin
            valid_q <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if ((ins_valid && ins_ready && ins_hit && ins_match[i]) ||
                    (ins_alloc && free_onehot[i])) begin
                    valid_q[i] <= 1'b1;
                    tag_q[i]   <= ins_ppn;
                    map_q[i]   <= ins_map;
                end
            end
        end
    end

    always_comb begin
        lk_map_sel = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (lk_match[i]) lk_map_sel = lk_map_sel | map_q[i];
        end
    end

    // Registered lookup response.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lk_out_valid <= 1'b0;
            lk_out_hit   <= 1'b0;
            lk_out_map   <= '0;
        end else begin
            lk_out_valid <= lk_valid;
            lk_out_hit   <= lk_valid && (|lk_match);
            lk_out_map   <= (|lk_match) ? lk_map_sel : lk_map_in;
        end
    end
endmodule

// File: rtl/rtb_checker.sv
`timescale 1ns/1ps
module rtb_checker #(
    parameter int DEPTH = 16,
    parameter int MAP_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             lk_valid,
    input logic [MAP_W-1:0] lk_map_in,
    input logic             lk_out_valid,
    input logic             lk_out_hit,
    input logic [MAP_W-1:0] lk_out_map,
    input logic             ins_valid,
    input logic             ins_ready,
    input logic             ins_hit,
    input logic             flush_req,
    input logic             flush_ack,
    input logic [DEPTH-1:0] valid_vec,
    input logic [DEPTH-1:0] lk_match
);
    // R10
    ready_when_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !flush_req |-> ins_ready);
    // R2
    resp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> lk_out_valid);
    // R2
    resp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !lk_out_valid);
    // R4
    miss_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_out_valid && !lk_out_hit) |-> (lk_out_map == $past(lk_map_in)));
    // R7
    flush_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_req && !flush_ack) |=> flush_req);
    // R7
    stall_new_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_req && ins_valid && !ins_hit) |-> !ins_ready);
    // R8
    flush_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_req && flush_ack) |=> (!flush_req && valid_vec == '0));
    // R5
    unique_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_match));
    // R6
    full_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (&valid_vec) |-> flush_req);
endmodule

bind remap_tag_buffer rtb_checker #(.DEPTH(DEPTH), .MAP_W(MAP_W)) u_rtb_chk (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_map_in(lk_map_in),
    .lk_out_valid(lk_out_valid), .lk_out_hit(lk_out_hit), .lk_out_map(lk_out_map),
    .ins_valid(ins_valid), .ins_ready(ins_ready), .ins_hit(ins_hit),
    .flush_req(flush_req), .flush_ack(flush_ack), .valid_vec(valid_q),
    .lk_match(lk_match));

// File: tb/tb_remap_tag_buffer.sv
`timescale 1ns/1ps
module tb_remap_tag_buffer;
    localparam int DEPTH = 16;
    localparam int PPN_W = 20;
    localparam int MAP_W = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lk_valid = 0, ins_valid = 0, flush_ack = 0;
    logic [PPN_W-1:0] lk_ppn = '0, ins_ppn = '0;
    logic [MAP_W-1:0] lk_map_in = '0, ins_map = '0;
    logic lk_out_valid, lk_out_hit, ins_ready, flush_req;
    logic [MAP_W-1:0] lk_out_map;

    int checks = 0, failures = 0;
    bit done = 0;

    // reference model state
    int unsigned m_ppn[$];
    logic [MAP_W-1:0] m_map[$];
    bit m_flush = 0;

    always #10 clk = ~clk;

    remap_tag_buffer #(.DEPTH(DEPTH), .PPN_W(PPN_W), .WAYS(4)) dut (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_ppn(lk_ppn),
        .lk_map_in(lk_map_in), .lk_out_valid(lk_out_valid), .lk_out_hit(lk_out_hit),
        .lk_out_map(lk_out_map), .ins_valid(ins_valid), .ins_ppn(ins_ppn),
        .ins_map(ins_map), .ins_ready(ins_ready), .flush_req(flush_req),
        .flush_ack(flush_ack));

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic int find(input int unsigned p);
        foreach (m_ppn[i]) if (m_ppn[i] == p) return i;
        return -1;
    endfunction

    task automatic drive(input bit lv, input int unsigned lp, input int lm,
                         input bit iv, input int unsigned ip, input int im, input bit ack);
        lk_valid = lv; lk_ppn = lp[PPN_W-1:0]; lk_map_in = lm[MAP_W-1:0];
        ins_valid = iv; ins_ppn = ip[PPN_W-1:0]; ins_map = im[MAP_W-1:0];
        flush_ack = ack;
    endtask

    // One clock: check ready, step model, check registered outputs.
    task automatic tick();
        int li, ii;
        bit exp_ready, e_hit;
        logic [MAP_W-1:0] e_map;
        bit e_valid;
        #1;
        ii = find(ins_ppn);
        exp_ready = m_flush ? (ii >= 0 && !flush_ack) : 1'b1;
        chk(m_flush ? "R7" : "R10", "ins_ready", ins_ready, exp_ready);
        li = find(lk_ppn);
        e_valid = lk_valid;
        e_hit = lk_valid && li >= 0;
        e_map = (li >= 0) ? m_map[li] : lk_map_in;
        if (m_flush && flush_ack) begin
            m_ppn.delete(); m_map.delete(); m_flush = 0;
        end else if (ins_valid && exp_ready) begin
            if (ii >= 0) m_map[ii] = ins_map;
            else begin
                m_ppn.push_back(ins_ppn); m_map.push_back(ins_map);
                if (m_ppn.size() == DEPTH) m_flush = 1;
            end
        end
        @(posedge clk); #1;
        chk("R6", "flush_req", flush_req, m_flush);
        chk("R2", "lk_out_valid", lk_out_valid, e_valid);
        if (e_valid) begin
            chk(e_hit ? "R3" : "R4", "lk_out_hit", lk_out_hit, e_hit);
            chk(e_hit ? "R3" : "R4", "lk_out_map", lk_out_map, e_map);
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "flush_req", flush_req, 0);
        chk("R1", "lk_out_valid", lk_out_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "ins_ready", ins_ready, 1);
        drive(1, 5, 6, 0, 0, 0, 0); tick();
        chk("R1", "empty miss", lk_out_hit, 0);

        // fill some pages, look up hits and misses
        for (int k = 0; k < 6; k++) begin drive(0, 0, 0, 1, 100 + k, k, 0); tick(); end
        for (int k = 0; k < 8; k++) begin drive(1, 98 + k, 7, 0, 0, 0, 0); tick(); end

        // R5: in-place updates
        drive(0, 0, 0, 1, 102, 5, 0); tick();
        drive(0, 0, 0, 1, 102, 2, 0); tick();
        drive(0, 0, 0, 1, 102, 7, 0); tick();
        drive(1, 102, 0, 0, 0, 0, 0); tick();
        chk("R5", "updated map", lk_out_map, 7);
        // lookup and insert same page same edge: old value returned
        drive(1, 102, 0, 1, 102, 1, 0); tick();
        chk("R3", "pre-insert value", lk_out_map, 7);

        // R9: ack with no flush pending
        drive(0, 0, 0, 0, 0, 0, 1); tick();
        drive(1, 101, 0, 0, 0, 0, 0); tick();
        chk("R9", "entry kept", lk_out_hit, 1);

        // fill to one free, with an update in between
        for (int k = 6; k < DEPTH - 1; k++) begin drive(0, 0, 0, 1, 100 + k, k, 0); tick(); end
        drive(0, 0, 0, 1, 100, 3, 0); tick();
        chk("R5", "no flush after update", flush_req, 0);
        drive(0, 0, 0, 1, 500, 4, 0); tick();
        chk("R6", "flush rises on fill", flush_req, 1);

        // R7: stall, update and lookups while pending
        drive(1, 500, 0, 1, 600, 1, 0); #1;
        chk("R7", "stall new page", ins_ready, 0);
        tick();
        drive(1, 600, 2, 1, 104, 6, 0); tick();
        chk("R7", "stalled page absent", lk_out_hit, 0);
        drive(1, 104, 0, 0, 0, 0, 0); tick();
        chk("R7", "held page updated", lk_out_map, 6);

        // R8: acknowledge
        drive(1, 104, 1, 1, 104, 3, 1); tick();
        chk("R8", "flush dropped", flush_req, 0);
        drive(1, 104, 1, 0, 0, 0, 0); tick();
        chk("R8", "entries cleared", lk_out_hit, 0);

        // random traffic
        for (int n = 0; n < 3000; n++) begin
            drive($urandom_range(3, 0) != 0, $urandom_range(23, 0), $urandom_range(7, 0),
                  $urandom_range(1, 0) == 1, $urandom_range(23, 0), $urandom_range(7, 0),
                  $urandom_range(5, 0) == 0);
            tick();
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule